// File: doc/BRIEF.md
# Serial Management PHY Register Slave

This block answers serial management frames the way an Ethernet PHY does. A host controls a single control register. Each write to that register sets the clock line and the data line of a two-wire management bus. A read of the register returns the present level of the data line. The block watches every transition of the clock bit in those writes and decodes the frame from them. It then either stores a 16-bit value in one of thirty-two registers or drives a register's value back onto the data line, one bit at a time.

The frame has the usual layout: a run of ones, a two-bit start pattern (`0` then `1`), a two-bit operation code, a five-bit PHY address, a five-bit register number, two turnaround bits and sixteen data bits. Every field is sent most significant bit first. Only PHY address 1 answers. Three registers are computed each time they are read, so the status, link-partner and diagnostic views all follow the advertisement register. Every other register reads back the value last stored in it.

Top module: `mdio_phy_slave`

## Requirements
- R1: After reset, reads at PHY address 1 return 0x3100 for register 0, 0x0300 for register 2, 0xE400 for register 3, 0x01E1 for register 4 and 0x0000 for every other register that is not computed.
- R2: A read of register 1 always returns 0x782C: bits 14..11 for speed and duplex abilities, bit 5 for negotiation done, bit 3 for negotiation ability and bit 2 for link up. Writes to register 1 do not change this value.
- R3: A read of register 5 returns 0x4000 ORed with bits 8..5 of register 4.
- R4: A read of register 18 returns 0x0C00 when bit 7 or bit 8 of register 4 is set, and 0x0000 otherwise.
- R5: A write frame to PHY address 1 stores its data in the addressed register, and a later read of any register that is not computed returns that value.
- R6: Frames that carry any PHY address other than 1 leave all registers unchanged and never drive the data line.
- R7: A frame is accepted only after at least 32 consecutive one-bits on the data line. If only 31 one-bits come before the start pattern, that frame is ignored.
- R8: If the second start bit is sampled low, `sof_miss` goes high for exactly one clock cycle after the write that completes that bit. Decoding then continues and the frame still takes effect.
- R9: Operation code 10 reads and 01 writes. Codes 00 and 11 store nothing.
- R10: Only a control write whose bit 2 (MDC) differs from the previous MDC value advances the decoder. Each frame bit occupies two such transitions, and its value is taken from the second transition.
- R11: On a read, `mdio_oe` rises with the transition that completes the second turnaround bit, and bit 15 then appears on the line. The line moves to the next bit at the completing transition of each data bit. It is released at the completing transition of the sixteenth data bit.
- R12: `ctl_rdata` bit 0 shows the bit the slave is sending while `mdio_oe` is high, and otherwise the last value written to control bit 0. All other bits of `ctl_rdata` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Write strobe for the management control register |
| ctl_wdata | input | CTL_W | Control write data: bit 0 data line, bit 2 clock line |
| ctl_rdata | output | CTL_W | Control read data: bit 0 is the present data-line level |
| mdio_oe | output | 1 | High while the slave drives the data line |
| sof_miss | output | 1 | One-cycle flag for a low second start bit |

## Verification
Two events can land on the same control write. The final transition of a read frame releases the line, and in that same write the host sets a new data-line value. The bench checks that `ctl_rdata` bit 0 at once shows the host value, which is 0, and not bit 0 of the register just read (register 4, whose bit 0 is 1). A second collision is provoked in the write phase. There the two transitions of each bit carry opposite data values, with an extra write between them that changes only the line level. The stored word must match the values from the completing transitions alone.

// File: rtl/mdio_phy_pkg.sv
// Shared types and constants for the serial management PHY slave.
// Assumes the usual two-bit operation codes; reset values are 16 bits wide.
package mdio_phy_pkg;

    typedef enum logic [2:0] {
        ST_PRE,
        ST_SOF,
        ST_OPC,
        ST_PHY,
        ST_REG,
        ST_TA,
        ST_DATA
    } frame_st_t;

    localparam logic [1:0] OPC_RD = 2'b10;
    localparam logic [1:0] OPC_WR = 2'b01;

    localparam logic [15:0] RST_CTRL = 16'h3100;
    localparam logic [15:0] RST_ID_HI = 16'h0300;
    localparam logic [15:0] RST_ID_LO = 16'hE400;
    localparam logic [15:0] RST_ADV = 16'h01E1;
    localparam logic [15:0] STATUS_VAL = 16'h782C;
    localparam logic [15:0] LP_BASE = 16'h4000;
    localparam logic [15:0] LP_MASK = 16'h01E0;
    localparam logic [15:0] DIAG_SRC = 16'h0180;
    localparam logic [15:0] DIAG_VAL = 16'h0C00;

endpackage

// File: rtl/mdio_frame_dec.sv
// Frame decoder for the management bus.
// Advances once per clock-line transition (step), so each bit takes two
// counter steps; field bits are taken on the second (completing) step.
// Assumes step is a single-cycle strobe and smp is the line value with it.
module mdio_frame_dec
    import mdio_phy_pkg::*;
#(
    parameter int AW       = 5,
    parameter int DW       = 16,
    parameter int PRE_BITS = 32,
    parameter int PHY_ADDR = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          smp,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          drive,
    output logic          tx_bit,
    output logic          sof_miss
);

    localparam int HMAX = (2 * PRE_BITS > 2 * DW) ? 2 * PRE_BITS : 2 * DW;
    localparam int CNT_W = $clog2(HMAX + 1);
    localparam logic [CNT_W-1:0] LIM_PRE  = CNT_W'(2 * PRE_BITS);
    localparam logic [CNT_W-1:0] LIM_TWO  = CNT_W'(4);
    localparam logic [CNT_W-1:0] LIM_ADDR = CNT_W'(2 * AW);
    localparam logic [CNT_W-1:0] LIM_DATA = CNT_W'(2 * DW);
    localparam logic [AW-1:0]    MY_ADDR  = AW'(PHY_ADDR);

    frame_st_t        st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_n;
    logic [1:0]       opc;
    logic [AW-1:0]    pad;
    logic [AW-1:0]    rad;
    logic [DW-1:0]    sh;
    logic             drv;
    logic             sof_q;

    // Next half-cycle count within the current field.
    assign cnt_n = cnt + 1'b1;

    // Write commit on the completing transition of the last data bit.
    assign wr_en   = step && (st == ST_DATA) && (cnt_n == LIM_DATA) &&
                     (opc == OPC_WR) && (pad == MY_ADDR) && !drv;
    assign wr_addr = rad;
    assign wr_data = {sh[DW-2:0], smp};
    assign rd_addr = rad;
    assign drive    = drv;
    assign tx_bit   = sh[DW-1];
    assign sof_miss = sof_q;

    // Frame state machine: counts half-cycles and shifts in fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_PRE;
            cnt   <= '0;
            opc   <= '0;
            pad   <= '0;
            rad   <= '0;
            sh    <= '0;
            drv   <= 1'b0;
            sof_q <= 1'b0;
        end else begin
            sof_q <= 1'b0;
            if (step) begin
                case (st)
                    ST_PRE: begin
                        if (smp) begin
                            if (cnt != LIM_PRE) cnt <= cnt_n;
                        end else if (cnt == LIM_PRE) begin
                            st  <= ST_SOF;
                            cnt <= CNT_W'(1);
                        end else begin
                            cnt <= '0;
                        end
                    end
                    ST_SOF: begin
                        cnt <= cnt_n;
                        if (cnt_n == LIM_TWO) begin
                            if (!smp) sof_q <= 1'b1;
                            st  <= ST_OPC;
                            cnt <= '0;
                        end
                    end
                    ST_OPC: begin
                        cnt <= cnt_n;
                        if (!cnt_n[0]) opc <= {opc[0], smp};
                        if (cnt_n == LIM_TWO) begin
                            st  <= ST_PHY;
                            cnt <= '0;
                        end
                    end
                    ST_PHY: begin
                        cnt <= cnt_n;
                        if (!cnt_n[0]) pad <= {pad[AW-2:0], smp};
                        if (cnt_n == LIM_ADDR) begin
                            st  <= ST_REG;
                            cnt <= '0;
                        end
                    end
                    ST_REG: begin
                        cnt <= cnt_n;
                        if (!cnt_n[0]) rad <= {rad[AW-2:0], smp};
                        if (cnt_n == LIM_ADDR) begin
                            st  <= ST_TA;
                            cnt <= '0;
                        end
                    end
                    ST_TA: begin
                        cnt <= cnt_n;
                        if (cnt_n == LIM_TWO) begin
                            st  <= ST_DATA;
                            cnt <= '0;
                            if (opc == OPC_RD && pad == MY_ADDR) begin
                                sh  <= rd_data;
                                drv <= 1'b1;
                            end
                        end
                    end
                    ST_DATA: begin
                        cnt <= cnt_n;
                        if (!cnt_n[0]) sh <= {sh[DW-2:0], (drv ? 1'b0 : smp)};
                        if (cnt_n == LIM_DATA) begin
                            st  <= ST_PRE;
                            cnt <= '0;
                            drv <= 1'b0;
                        end
                    end
                    default: begin
                        st  <= ST_PRE;
                        cnt <= '0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/mdio_phy_regs.sv
// PHY register file: 2**AW stored words plus three registers computed on read.
// Writes to computed registers are stored but never show on their read.
// Assumes DW is 16 so the reset and computed constants fit exactly.
module mdio_phy_regs
    import mdio_phy_pkg::*;
#(
    parameter int AW       = 5,
    parameter int DW       = 16,
    parameter int STAT_REG = 1,
    parameter int ADV_REG  = 4,
    parameter int LP_REG   = 5,
    parameter int DIAG_REG = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int NREG = 1 << AW;

    logic [DW-1:0] words [NREG];
    logic [DW-1:0] adv;

    function automatic logic [DW-1:0] rst_val(input int idx);
        case (idx)
            0:       return DW'(RST_CTRL);
            2:       return DW'(RST_ID_HI);
            3:       return DW'(RST_ID_LO);
            ADV_REG: return DW'(RST_ADV);
            default: return '0;
        endcase
    endfunction

    for (genvar g = 0; g < NREG; g++) begin : g_word
        logic [DW-1:0] q;
        // One storage word with its own reset value and write decode.
        always_ff @(posedge clk) begin
            if (!rst_n)                               q <= rst_val(g);
            else if (wr_en && wr_addr == AW'(g))      q <= wr_data;
        end
        assign words[g] = q;
    end

    assign adv = words[ADV_REG];

    // Read mux: computed views first, stored words otherwise.
    always_comb begin
        if (rd_addr == AW'(STAT_REG))
            rd_data = DW'(STATUS_VAL);
        else if (rd_addr == AW'(LP_REG))
            rd_data = DW'(LP_BASE) | (adv & DW'(LP_MASK));
        else if (rd_addr == AW'(DIAG_REG))
            rd_data = ((adv & DW'(DIAG_SRC)) != '0) ? DW'(DIAG_VAL) : '0;
        else
            rd_data = words[rd_addr];
    end

endmodule

// File: rtl/mdio_phy_slave.sv
// Top level: host control register that bit-bangs the management bus,
// feeding the frame decoder and PHY register file.
// Assumes control bit 0 is the data line and bit 2 the clock line.
module mdio_phy_slave #(
    parameter int CTL_W    = 32,
    parameter int AW       = 5,
    parameter int DW       = 16,
    parameter int PRE_BITS = 32,
    parameter int PHY_ADDR = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    output logic             mdio_oe,
    output logic             sof_miss
);

    localparam int MDIO_BIT = 0;
    localparam int MDC_BIT  = 2;

    logic          mdc_q;
    logic          host_q;
    logic          step;
    logic          reg_wr_en;
    logic [AW-1:0] reg_wr_addr;
    logic [DW-1:0] reg_wr_data;
    logic [AW-1:0] reg_rd_addr;
    logic [DW-1:0] reg_rd_data;
    logic          tx_bit;
    logic          unused_ctl;

    assign unused_ctl = ^ctl_wdata;

    // A decoder step is any control write that changes the clock bit.
    assign step = ctl_we && (ctl_wdata[MDC_BIT] != mdc_q);

    // Host-side line levels held from the last control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_q  <= 1'b0;
            host_q <= 1'b0;
        end else if (ctl_we) begin
            mdc_q  <= ctl_wdata[MDC_BIT];
            host_q <= ctl_wdata[MDIO_BIT];
        end
    end

    assign ctl_rdata = {{(CTL_W-1){1'b0}}, (mdio_oe ? tx_bit : host_q)};

    mdio_frame_dec #(
        .AW(AW), .DW(DW), .PRE_BITS(PRE_BITS), .PHY_ADDR(PHY_ADDR)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .smp      (ctl_wdata[MDIO_BIT]),
        .rd_data  (reg_rd_data),
        .rd_addr  (reg_rd_addr),
        .wr_en    (reg_wr_en),
        .wr_addr  (reg_wr_addr),
        .wr_data  (reg_wr_data),
        .drive    (mdio_oe),
        .tx_bit   (tx_bit),
        .sof_miss (sof_miss)
    );

    mdio_phy_regs #(
        .AW(AW), .DW(DW)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_wr_addr),
        .wr_data (reg_wr_data),
        .rd_addr (reg_rd_addr),
        .rd_data (reg_rd_data)
    );

endmodule

// File: rtl/mdio_phy_slave_chk.sv
// Checker for the management PHY slave, attached by bind below.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module mdio_phy_slave_chk #(
    parameter int CTL_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_we,
    input logic [CTL_W-1:0] ctl_rdata,
    input logic             mdio_oe,
    input logic             sof_miss,
    input logic             wr_en
);

    assert_oe_rise_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> $past(ctl_we));

    assert_sof_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sof_miss |=> !sof_miss);

    assert_sof_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sof_miss) |-> $past(ctl_we));

    assert_rdata_upper_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[CTL_W-1:1] == '0);

    assert_quiet_without_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> ($stable(ctl_rdata) && $stable(mdio_oe)));

    assert_commit_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ctl_we);

    assert_commit_ends_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !mdio_oe);

endmodule

bind mdio_phy_slave mdio_phy_slave_chk #(.CTL_W(CTL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_rdata (ctl_rdata),
    .mdio_oe   (mdio_oe),
    .sof_miss  (sof_miss),
    .wr_en     (reg_wr_en)
);

// File: tb/sim_mdio_phy_slave.sv
`timescale 1ns/1ps
module sim_mdio_phy_slave;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctl_we;
    logic [31:0] ctl_wdata;
    logic [31:0] ctl_rdata;
    logic        mdio_oe;
    logic        sof_miss;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [15:0] mdl [32];
    logic        done = 1'b0;

    always #2.5 clk = ~clk;

    mdio_phy_slave u0 (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .mdio_oe(mdio_oe), .sof_miss(sof_miss)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic cw(input logic c, input logic d);
        @(negedge clk);
        ctl_we    = 1'b1;
        ctl_wdata = {29'b0, c, 1'b0, d};
        @(negedge clk);
        ctl_we    = 1'b0;
    endtask

    task automatic bitx(input logic b);
        cw(1'b1, b);
        cw(1'b0, b);
    endtask

    task automatic pre(input int n);
        for (int i = 0; i < n; i++) bitx(1'b1);
    endtask

    task automatic hdr(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra);
        bitx(1'b0);
        bitx(1'b1);
        for (int i = 1; i >= 0; i--) bitx(op[i]);
        for (int i = 4; i >= 0; i--) bitx(pa[i]);
        for (int i = 4; i >= 0; i--) bitx(ra[i]);
    endtask

    task automatic wr_frame(input logic [1:0] op, input logic [4:0] pa,
                            input logic [4:0] ra, input logic [15:0] d);
        pre(32);
        hdr(op, pa, ra);
        bitx(1'b1);
        bitx(1'b0);
        for (int i = 15; i >= 0; i--) bitx(d[i]);
    endtask

    // Read frame; host drives 0 through turnaround and data.
    task automatic rd_frame(input logic [4:0] pa, input logic [4:0] ra,
                            output logic [15:0] d, output logic oe_ta1,
                            output logic oe_all, output logic oe_any,
                            output logic lvl_end, output logic oe_end);
        pre(32);
        hdr(2'b10, pa, ra);
        bitx(1'b0);
        oe_ta1 = mdio_oe;
        bitx(1'b0);
        oe_all = 1'b1;
        oe_any = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            d[i]   = ctl_rdata[0];
            oe_all = oe_all & mdio_oe;
            oe_any = oe_any | mdio_oe;
            bitx(1'b0);
        end
        lvl_end = ctl_rdata[0];
        oe_end  = mdio_oe;
    endtask

    function automatic logic [15:0] exp_rd(input int ra);
        case (ra)
            1:       return 16'h782C;
            5:       return 16'h4000 | (mdl[4] & 16'h01E0);
            18:      return ((mdl[4] & 16'h0180) != 0) ? 16'h0C00 : 16'h0000;
            default: return mdl[ra];
        endcase
    endfunction

    task automatic rd_check(input string rq, input int ra);
        logic [15:0] d;
        logic ta1, all, any, lv, oe_e;
        rd_frame(5'd1, 5'(ra), d, ta1, all, any, lv, oe_e);
        chk(rq, {16'h0, d}, {16'h0, exp_rd(ra)});
        if (ta1 !== 1'b0 || all !== 1'b1 || oe_e !== 1'b0) begin
            chk("R11 drive window", {29'b0, ta1, all, oe_e}, 32'b010);
        end
        if (lv !== 1'b0) chk("R12 release level", {31'b0, lv}, 32'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic ta1, all, any, lv, oe_e;
        for (int i = 0; i < 32; i++) mdl[i] = 16'h0;
        mdl[0] = 16'h3100; mdl[2] = 16'h0300; mdl[3] = 16'hE400; mdl[4] = 16'h01E1;
        rst_n = 1'b0; ctl_we = 1'b0; ctl_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset rdata", ctl_rdata, 32'h0);
        chk("R11 reset oe", {31'b0, mdio_oe}, 32'h0);
        chk("R8 reset sof_miss", {31'b0, sof_miss}, 32'h0);

        // R1 R2 R3 R4: sweep every register after reset
        for (int ra = 0; ra < 32; ra++) rd_check("R1 R2 R3 R4 reset sweep", ra);

        // R11 R12: explicit drive window on register 4 (bit 0 set, host sends 0)
        rd_frame(5'd1, 5'd4, d, ta1, all, any, lv, oe_e);
        chk("R11 oe low after first turnaround bit", {31'b0, ta1}, 32'h0);
        chk("R11 oe high through data", {31'b0, all}, 32'h1);
        chk("R11 released after last bit", {31'b0, oe_e}, 32'h0);
        chk("R12 host level wins at release", {31'b0, lv}, 32'h0);

        // R5: write every register, then read all back
        for (int ra = 0; ra < 32; ra++) begin
            logic [15:0] v;
            v = 16'((ra * 16'h1357) ^ 16'hC0DE);
            wr_frame(2'b01, 5'd1, 5'(ra), v);
            mdl[ra] = v;
        end
        for (int ra = 0; ra < 32; ra++) rd_check("R5 R2 write sweep", ra);

        // R3 R4: advertisement bit 7/8 combinations
        for (int k = 0; k < 4; k++) begin
            logic [15:0] v;
            v = 16'((k << 7) | 16'h0061);
            wr_frame(2'b01, 5'd1, 5'd4, v);
            mdl[4] = v;
            rd_check("R3 link partner", 5);
            rd_check("R4 diagnostic", 18);
            rd_check("R2 status", 1);
        end

        // R6: other PHY addresses
        for (int pa = 0; pa < 32; pa++) begin
            if (pa != 1) begin
                wr_frame(2'b01, 5'(pa), 5'd0, ~mdl[0]);
                rd_frame(5'(pa), 5'd0, d, ta1, all, any, lv, oe_e);
                if (any !== 1'b0 || d !== 16'h0)
                    chk("R6 foreign read undriven", {15'b0, any, d}, 32'h0);
            end
        end
        n_chk++;
        rd_check("R6 register 0 untouched", 0);

        // R7: 31 preamble bits are not enough (previous frame ended in zeros)
        pre(31);
        hdr(2'b01, 5'd1, 5'd0);
        bitx(1'b1); bitx(1'b0);
        for (int i = 15; i >= 0; i--) bitx(1'(16'h1234 >> i));
        rd_check("R7 short preamble ignored", 0);

        // R8: normal start leaves flag low; low second start bit flags
        pre(32);
        bitx(1'b0); bitx(1'b1);
        chk("R8 good start no flag", {31'b0, sof_miss}, 32'h0);
        for (int i = 0; i < 14; i++) bitx(1'b0);
        for (int i = 0; i < 18; i++) bitx(1'b0);
        pre(32);
        bitx(1'b0); bitx(1'b0);
        chk("R8 missing start flagged", {31'b0, sof_miss}, 32'h1);
        @(negedge clk);
        chk("R8 flag one cycle", {31'b0, sof_miss}, 32'h0);
        bitx(1'b0); bitx(1'b1);
        for (int i = 4; i >= 0; i--) bitx(1'(5'd1 >> i));
        for (int i = 4; i >= 0; i--) bitx(1'(5'd7 >> i));
        bitx(1'b1); bitx(1'b0);
        for (int i = 15; i >= 0; i--) bitx(1'(16'hBEEF >> i));
        mdl[7] = 16'hBEEF;
        rd_check("R8 decoding continues", 7);

        // R9: opcodes 11 and 00 store nothing
        wr_frame(2'b11, 5'd1, 5'd9, 16'h0F0F);
        wr_frame(2'b00, 5'd1, 5'd9, 16'hF0F0);
        rd_check("R9 non-write opcodes ignored", 9);

        // R10 R12: first edge carries inverted data, extra same-MDC write
        pre(32);
        hdr(2'b01, 5'd1, 5'd10);
        bitx(1'b1); bitx(1'b0);
        for (int i = 15; i >= 0; i--) begin
            logic b;
            b = 1'(16'h5A3C >> i);
            cw(1'b1, ~b);
            cw(1'b1, b);
            if (ctl_rdata[0] !== b) chk("R12 level follows host", {31'b0, ctl_rdata[0]}, {31'b0, b});
            cw(1'b0, b);
        end
        mdl[10] = 16'h5A3C;
        rd_check("R10 completing edge sampled", 10);
        n_chk++;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule